// File: doc/BRIEF.md
# Quad-Phase Fetch/Execute Sequencer

This block sets the timing and controls the pipeline at the core of a small controller. A free-running two-bit counter splits every instruction cycle into four one-hot phase strobes. The strobes gate every state change: the program counter moves to a new fetch address at the start of Q1. The word on the program-memory bus is latched at the end of Q4. That word enters the instruction register at the end of Q1 of the following cycle. Data-memory read and write strobes appear in Q2 and Q4 of the executing instruction.

Fetch and execute overlap, so straight-line code completes one instruction per four-clock cycle. A small decode stub outside the block looks at the instruction register. When it sees a branch, it raises a request with a target address. The sequencer then loads the target as the next fetch address. The word already fetched behind the branch is turned into an all-zero no-op, so a taken branch costs two instruction cycles.

The opcode class sits in the top two bits of the instruction word: 00 is a no-op, 01 is a data operation, 10 is a branch, and 11 is treated as a no-op.

Top module: `qphase_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters Q1 (`phase` = 0001), `pmAddr` = 0, `ir` = 0, and both data strobes stay low.
- R2: `phase` is always one-hot. It rotates Q1→Q2→Q3→Q4→Q1 (bits 0,1,2,3) on every clock after reset.
- R3: `pmAddr` changes only when the block enters Q1. It holds steady through Q2, Q3 and Q4.
- R4: With no taken branch, each new instruction cycle presents the previous `pmAddr` plus 2.
- R5: `ir` changes only when the block enters Q2. It then holds the word that `pmData` carried at the end of Q4 of the previous instruction cycle.
- R6: `dmRd` is high exactly in Q2, and `dmWr` exactly in Q4, of a cycle whose `ir` has opcode class 01. Both stay low for every other class and phase.
- R7: If `brReq` is high at the end of Q4 while `ir` holds class 10, the next cycle's `pmAddr` equals `brTarget` with bit 0 forced to 0.
- R8: After a taken branch, `ir` holds 0 for the next instruction cycle (the fetched word is discarded). The cycle after that holds the word read at the target address.
- R9: `brReq` has no effect while `ir` holds any class other than 10. The fetch address then steps by 2 as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four per instruction cycle |
| rst | input | 1 | Synchronous active-high reset |
| pmData | input | IW | Program-memory read word for `pmAddr` |
| brReq | input | 1 | Branch request from the decode stub |
| brTarget | input | AW | Branch target address |
| pmAddr | output | AW | Program-memory fetch address |
| phase | output | 4 | One-hot phase strobes, bit 0 = Q1 |
| ir | output | IW | Instruction register |
| dmRd | output | 1 | Data-memory operand read strobe |
| dmWr | output | 1 | Data-memory destination write strobe |

## Verification
Assertions check on every cycle that the phase is one-hot and rotates, that the fetch address and the instruction register change only in their own phases, and that the data strobes stay in their phases. They also check that a taken branch loads the even target and leaves a zero bubble, and that an untaken cycle steps the address by 2. Only the bench's model of the program memory can show that the instruction register holds exactly the word fetched one cycle earlier. The bench also shows that a request arriving during a no-op, a data operation or a bubble is ignored, and that the target word really follows the bubble.

// File: rtl/qphase_pkg.sv
`timescale 1ns/1ps
package qphase_pkg;
  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_e;

  typedef enum logic [1:0] {
    OP_NOP    = 2'b00,
    OP_DATA   = 2'b01,
    OP_BRANCH = 2'b10,
    OP_RSVD   = 2'b11
  } opclass_e;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic latchFetch;  // capture program word (end of Q4)
    logic stepPc;      // sequential advance (end of Q4)
    logic jumpPc;      // load branch target (end of Q4)
    logic loadIr;      // move fetched word into IR (end of Q1)
    logic insertNop;   // replace fetched word with a bubble
  } seqStrobes_t;
endpackage

// File: rtl/qphase_ctrl.sv
`timescale 1ns/1ps
module qphase_ctrl
  import qphase_pkg::*;
#(
  parameter int NPH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  opclass_e          irOp,
  input  logic              brReq,
  output seqStrobes_t       strb,
  output logic [NPH-1:0]    phase,
  output logic              dmRd,
  output logic              dmWr
);
  phase_e phCnt;
  logic   flushPend;
  logic   takeBranch;

  assign takeBranch = (phCnt == PH_Q4) && brReq && (irOp == OP_BRANCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      phCnt     <= PH_Q1;
      flushPend <= 1'b0;
    end else begin
      phCnt <= phase_e'(phCnt + 2'd1);
      if (takeBranch)
        flushPend <= 1'b1;
      else if (phCnt == PH_Q1)
        flushPend <= 1'b0;
    end
  end

  always_comb begin
    strb.latchFetch = (phCnt == PH_Q4);
    strb.stepPc     = (phCnt == PH_Q4) && !takeBranch;
    strb.jumpPc     = takeBranch;
    strb.loadIr     = (phCnt == PH_Q1);
    strb.insertNop  = flushPend;
  end

  for (genvar k = 0; k < NPH; k++) begin : g_phase
    assign phase[k] = (phCnt == phase_e'(k));
  end

  assign dmRd = (phCnt == PH_Q2) && (irOp == OP_DATA);
  assign dmWr = (phCnt == PH_Q4) && (irOp == OP_DATA);
endmodule

// File: rtl/qphase_dpath.sv
`timescale 1ns/1ps
module qphase_dpath
  import qphase_pkg::*;
#(
  parameter int AW      = 12,
  parameter int IW      = 16,
  parameter int PC_STEP = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  seqStrobes_t     strb,
  input  logic [IW-1:0]   pmData,
  input  logic [AW-1:0]   brTarget,
  output logic [AW-1:0]   pmAddr,
  output logic [IW-1:0]   ir,
  output opclass_e        irOp
);
  localparam logic [AW-1:0] STEP_V   = AW'(PC_STEP);
  localparam logic [AW-1:0] EVEN_MSK = ~AW'(1);

  logic [AW-1:0] pcReg;
  logic [IW-1:0] fetchBuf;
  logic [IW-1:0] irReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg    <= '0;
      fetchBuf <= '0;
      irReg    <= '0;
    end else begin
      if (strb.latchFetch)
        fetchBuf <= pmData;
      if (strb.jumpPc)
        pcReg <= brTarget & EVEN_MSK;
      else if (strb.stepPc)
        pcReg <= pcReg + STEP_V;
      if (strb.loadIr)
        irReg <= strb.insertNop ? '0 : fetchBuf;
    end
  end

  assign pmAddr = pcReg;
  assign ir     = irReg;
  assign irOp   = opclass_e'(irReg[IW-1 -: 2]);
endmodule

// File: rtl/qphase_seq.sv
`timescale 1ns/1ps
module qphase_seq
  import qphase_pkg::*;
#(
  parameter int AW = 12,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] pmData,
  input  logic          brReq,
  input  logic [AW-1:0] brTarget,
  output logic [AW-1:0] pmAddr,
  output logic [3:0]    phase,
  output logic [IW-1:0] ir,
  output logic          dmRd,
  output logic          dmWr
);
  seqStrobes_t strb;
  opclass_e    irOp;

  qphase_ctrl #(.NPH(4)) ctrl_i (
    .clk(clk), .rst(rst), .irOp(irOp), .brReq(brReq),
    .strb(strb), .phase(phase), .dmRd(dmRd), .dmWr(dmWr)
  );

  qphase_dpath #(.AW(AW), .IW(IW), .PC_STEP(2)) dpath_i (
    .clk(clk), .rst(rst), .strb(strb), .pmData(pmData),
    .brTarget(brTarget), .pmAddr(pmAddr), .ir(ir), .irOp(irOp)
  );
endmodule

// File: rtl/qphase_chk.sv
`timescale 1ns/1ps
module qphase_chk #(
  parameter int AW = 12,
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] pmAddr,
  input logic [3:0]    phase,
  input logic [IW-1:0] ir,
  input logic          brReq,
  input logic [AW-1:0] brTarget,
  input logic          dmRd,
  input logic          dmWr
);
  logic isBranch;
  assign isBranch = (ir[IW-1 -: 2] == 2'b10);

  a_r2_phase_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(phase) == 1);

  a_r2_phase_rotate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase == {$past(phase[2:0]), $past(phase[3])}));

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !phase[0] |-> $stable(pmAddr));

  a_r5_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !phase[1] |-> $stable(ir));

  a_r6_rd_in_q2: assert property (@(posedge clk) disable iff (rst)
    dmRd |-> phase[1]);

  a_r6_wr_in_q4: assert property (@(posedge clk) disable iff (rst)
    dmWr |-> phase[3]);

  a_r7_branch_target: assert property (@(posedge clk) disable iff (rst)
    (phase[3] && brReq && isBranch) |=> (pmAddr == {$past(brTarget[AW-1:1]), 1'b0}));

  a_r8_bubble: assert property (@(posedge clk) disable iff (rst)
    (phase[3] && brReq && isBranch) |=> ##1 (ir == '0));

  a_r9_sequential_step: assert property (@(posedge clk) disable iff (rst)
    (phase[3] && !isBranch) |=> (pmAddr == $past(pmAddr) + AW'(2)));
endmodule

bind qphase_seq qphase_chk #(.AW(AW), .IW(IW)) chk_i (
  .clk(clk), .rst(rst), .pmAddr(pmAddr), .phase(phase), .ir(ir),
  .brReq(brReq), .brTarget(brTarget), .dmRd(dmRd), .dmWr(dmWr)
);

// File: tb/qphase_seq_tb_top.sv
`timescale 1ns/1ps
module qphase_seq_tb_top;
  localparam int AW = 12;
  localparam int IW = 16;
  localparam int MW = 128;
  localparam int NRAND = 2000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [IW-1:0] pmData;
  logic          brReq = 1'b0;
  logic [AW-1:0] brTarget = '0;
  logic [AW-1:0] pmAddr;
  logic [3:0]    phase;
  logic [IW-1:0] ir;
  logic          dmRd, dmWr;

  logic [IW-1:0] progMem [MW];

  int nChecks = 0;
  int nFails  = 0;

  logic [AW-1:0] expPc;
  logic [IW-1:0] expIr, expBuf;
  logic          expFlush, lastTake, lastReq, lastBubble;

  always #10 clk = ~clk;

  assign pmData = progMem[pmAddr[7:1]];

  qphase_seq #(.AW(AW), .IW(IW)) dut_i (
    .clk(clk), .rst(rst), .pmData(pmData), .brReq(brReq), .brTarget(brTarget),
    .pmAddr(pmAddr), .phase(phase), .ir(ir), .dmRd(dmRd), .dmWr(dmWr)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] opOf(input logic [IW-1:0] w);
    return w[IW-1 -: 2];
  endfunction

  function automatic logic [AW-1:0] modelNextPc(input logic [AW-1:0] pc, input logic take,
                                                input logic [AW-1:0] tgt);
    return take ? {tgt[AW-1:1], 1'b0} : pc + AW'(2);
  endfunction

  function automatic logic [IW-1:0] mkWord(input logic [1:0] op, input logic [IW-3:0] rest);
    return {op, rest};
  endfunction

  // one instruction cycle; entered and left at the falling edge inside Q1
  task automatic runCycle(input logic req, input logic [AW-1:0] tgt);
    logic take;
    string pcTag;
    pcTag = lastTake ? "R7" : (lastReq ? "R9" : "R4");
    check("R2", "phase in Q1", 32'(phase), 32'h1);
    check(pcTag, "fetch address", 32'(pmAddr), 32'(expPc));
    check("R6", "strobes in Q1", {30'd0, dmRd, dmWr}, 32'd0);
    brReq    = req;
    brTarget = tgt;
    @(negedge clk);
    expIr    = expFlush ? '0 : expBuf;
    lastBubble = expFlush;
    expFlush = 1'b0;
    check("R2", "phase in Q2", 32'(phase), 32'h2);
    check(lastBubble ? "R8" : "R5", "ir after load", 32'(ir), 32'(expIr));
    check("R6", "dmRd in Q2", 32'(dmRd), 32'(opOf(expIr) == 2'b01));
    check("R6", "dmWr in Q2", 32'(dmWr), 32'd0);
    check("R3", "addr held in Q2", 32'(pmAddr), 32'(expPc));
    @(negedge clk);
    check("R2", "phase in Q3", 32'(phase), 32'h4);
    check("R6", "strobes in Q3", {30'd0, dmRd, dmWr}, 32'd0);
    check("R5", "ir held in Q3", 32'(ir), 32'(expIr));
    @(negedge clk);
    check("R2", "phase in Q4", 32'(phase), 32'h8);
    check("R6", "dmWr in Q4", 32'(dmWr), 32'(opOf(expIr) == 2'b01));
    check("R6", "dmRd in Q4", 32'(dmRd), 32'd0);
    check("R3", "addr held in Q4", 32'(pmAddr), 32'(expPc));
    take     = req && (opOf(expIr) == 2'b10);
    expBuf   = progMem[expPc[7:1]];
    expPc    = modelNextPc(expPc, take, tgt);
    expFlush = take;
    lastTake = take;
    lastReq  = req;
    @(negedge clk);
    if (lastBubble)
      check("R8", "bubble ir held through Q1", 32'(ir), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < MW; i++) progMem[i] = IW'($urandom);
    // directed program: data op, branch, data op that must be flushed
    progMem[0]    = mkWord(2'b01, 14'h0011);
    progMem[1]    = mkWord(2'b10, 14'h0022);
    progMem[2]    = mkWord(2'b01, 14'h0033);
    progMem[3]    = mkWord(2'b01, 14'h0044);
    progMem[8'h20] = mkWord(2'b01, 14'h0055);
    progMem[8'h21] = mkWord(2'b00, 14'h0066);

    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "reset phase", 32'(phase), 32'h1);
    check("R1", "reset addr", 32'(pmAddr), 32'd0);
    check("R1", "reset ir", 32'(ir), 32'd0);
    check("R1", "reset strobes", {30'd0, dmRd, dmWr}, 32'd0);
    rst = 1'b0;

    expPc = '0; expIr = '0; expBuf = '0; expFlush = 1'b0;
    lastTake = 1'b0; lastReq = 1'b0; lastBubble = 1'b0;

    // R9: request during the reset no-op and during a data op is ignored
    runCycle(1'b1, AW'(12'h0F0));
    runCycle(1'b1, AW'(12'h0F0));
    // R7: branch with odd target, bit 0 dropped
    runCycle(1'b1, AW'(12'h041));
    // R8: bubble, and a request during the bubble is ignored (R9)
    runCycle(1'b1, AW'(12'h010));
    check("R8", "target word follows bubble", 32'(pmAddr), 32'h42);
    runCycle(1'b0, '0);
    check("R8", "target word in ir", 32'(ir), 32'(progMem[8'h20]));
    runCycle(1'b0, '0);

    for (int n = 0; n < NRAND; n++) begin
      logic          rq;
      logic [AW-1:0] tg;
      rq = ($urandom % 3) == 0;
      tg = (($urandom % 8) == 0) ? AW'($urandom % 256) : AW'(($urandom % MW) * 2);
      runCycle(rq, tg);
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule